// File: doc/BRIEF.md
# Subset-Sum Range Search Kernel

This kernel runs a brute-force subset-sum search. Before a run, a bank of M object weights is written one entry at a time. A run starts with a one-cycle pulse on `go`, which supplies a target total and an inclusive range of subset masks. In a mask, bit i set means object i is in the subset. The kernel then visits each mask in the range in ascending order, one per cycle. For each mask it adds up the selected weights, compares the total with the target, and presents every exact match on a valid/ready output stream. When the output is not ready, the walk stalls on the matching mask.

Each kernel searches only the slice of the mask space it is given at start time. Many identical kernels can therefore split one large search between them. The total is formed with plain additions, either as a balanced adder tree or as a linear chain (chosen by parameter). The total is wide enough that it never wraps. When the last mask of the range has been handled, `done` rises and `match_count` holds the number of matches delivered.

Top module: `ssk_range_kernel`

## Requirements
- R1: A weight write (`wt_we` high, index `wt_idx`, value `wt_data`) takes effect at the clock edge while the kernel is idle. A weight write while `busy` is high is ignored.
- R2: A `go` pulse while idle captures `target`, `start_mask` and `end_mask`. Later changes on those inputs, and any `go` pulse while `busy`, have no effect on the run in progress.
- R3: A mask's total is the sum of weight i over every set bit i. The total is WW+clog2(M+1) bits wide and does not overflow, even with every weight at its maximum value and every bit set.
- R4: Starting with `start_mask`, the kernel checks one mask per cycle in ascending order up to and including `end_mask`. Each cycle in which a match waits for `ready` adds exactly one cycle to the run.
- R5: A mask whose total equals the target appears on `match_mask` with `match_valid` high. It stays stable until `match_ready` is high at a clock edge. `match_valid` is never high for a mask that does not match.
- R6: The clock edge that completes the check of `end_mask` drops `busy` and raises `done`. `done` stays high until the next accepted `go`.
- R7: `match_count` is cleared by an accepted `go` and increases by one for each match handed over on the stream.
- R8: If `start_mask` is greater than `end_mask`, no mask is checked. `done` is high and `busy` is low right after the accepting edge, and the count is zero.
- R9: Reset clears all weights to zero and leaves `busy`, `done`, `match_valid` low and `match_count` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wt_we | input | 1 | Weight write strobe |
| wt_idx | input | IDX_W | Object index of the weight being written |
| wt_data | input | WW | Weight value |
| target | input | SUM_W | Target total, captured on an accepted go |
| start_mask | input | M | First subset mask of the range |
| end_mask | input | M | Last subset mask of the range (inclusive) |
| go | input | 1 | Start pulse, accepted while idle |
| match_valid | output | 1 | A matching mask is presented |
| match_ready | input | 1 | Consumer accepts the presented mask |
| match_mask | output | M | Subset mask of the current match |
| busy | output | 1 | A range is being searched |
| done | output | 1 | The last run finished |
| match_count | output | M+1 | Matches delivered in the current or last run |

## Verification
The assertions take for granted that `go` arrives as a single-cycle pulse. They also assume that the consumer may hold `match_ready` low for any number of cycles, and that the weight bank does not change during a run. That last point is guaranteed by R1 rather than by the environment. The stimulus drives every input on the falling clock edge and keeps ready patterns finite, so every run ends. On purpose, it also pokes weights, scrambles the captured inputs and re-pulses `go` in the middle of a run, so that the cases the design must ignore actually occur.

// File: rtl/ssk_pkg.sv
package ssk_pkg;
   typedef enum logic {
      SK_IDLE = 1'b0,
      SK_SCAN = 1'b1
   } sk_state_e;

   function automatic int sk_sum_width(input int n_obj, input int w_bits);
      return w_bits + $clog2(n_obj + 1);
   endfunction
endpackage

// File: rtl/ssk_weight_bank.sv
module ssk_weight_bank #(
   parameter int M     = 8,
   parameter int WW    = 8,
   parameter int IDX_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [WW-1:0]   wr_val,
   output logic [M*WW-1:0] w_flat
);
   for (genvar i = 0; i < M; i++) begin : g_slot
      logic [WW-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot_q <= '0;
         else if (wr_en && (wr_idx == IDX_W'(i)))
            slot_q <= wr_val;
      end
      assign w_flat[i*WW +: WW] = slot_q;
   end
endmodule

// File: rtl/ssk_sum_unit.sv
module ssk_sum_unit #(
   parameter int M          = 8,
   parameter int WW         = 8,
   parameter int SW         = 12,
   parameter bit ADDER_TREE = 1'b1
) (
   input  logic [M*WW-1:0] w_flat,
   input  logic [M-1:0]    sel,
   output logic [SW-1:0]   total
);
   localparam int LV = (M > 1) ? $clog2(M) : 0;
   localparam int P  = 1 << LV;

   if (ADDER_TREE) begin : g_tree
      always_comb begin
         logic [SW-1:0] nd [2*P-1];
         for (int i = 0; i < P; i++) begin
            if (i < M && sel[i])
               nd[P-1+i] = {{(SW-WW){1'b0}}, w_flat[i*WW +: WW]};
            else
               nd[P-1+i] = '0;
         end
         for (int j = P - 2; j >= 0; j--)
            nd[j] = nd[2*j+1] + nd[2*j+2];
         total = nd[0];
      end
   end else begin : g_chain
      always_comb begin
         logic [SW-1:0] acc;
         acc = '0;
         for (int i = 0; i < M; i++)
            if (sel[i])
               acc = acc + {{(SW-WW){1'b0}}, w_flat[i*WW +: WW]};
         total = acc;
      end
   end
endmodule

// File: rtl/ssk_walker.sv
module ssk_walker
   import ssk_pkg::*;
#(
   parameter int M  = 8,
   parameter int CW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [M-1:0]  first,
   input  logic [M-1:0]  last,
   input  logic          hit,
   input  logic          out_ready,
   output logic [M-1:0]  cur,
   output logic          out_valid,
   output logic          scanning,
   output logic          finished,
   output logic [CW-1:0] hits
);
   localparam logic [M-1:0]  ONE  = M'(1);
   localparam logic [CW-1:0] CONE = CW'(1);

   sk_state_e     st_q;
   logic [M-1:0]  cur_q, last_q;
   logic          fin_q;
   logic [CW-1:0] cnt_q;
   logic          accept, adv, empty;

   assign scanning  = (st_q == SK_SCAN);
   assign accept    = go && !scanning;
   assign empty     = first > last;
   assign out_valid = scanning && hit;
   assign adv       = scanning && (!hit || out_ready);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= SK_IDLE;
         cur_q  <= '0;
         last_q <= '0;
         fin_q  <= 1'b0;
         cnt_q  <= '0;
      end else if (accept) begin
         cnt_q  <= '0;
         cur_q  <= first;
         last_q <= last;
         fin_q  <= empty;
         st_q   <= empty ? SK_IDLE : SK_SCAN;
      end else if (adv) begin
         if (hit)
            cnt_q <= cnt_q + CONE;
         if (cur_q == last_q) begin
            st_q  <= SK_IDLE;
            fin_q <= 1'b1;
         end else begin
            cur_q <= cur_q + ONE;
         end
      end
   end

   assign cur      = cur_q;
   assign finished = fin_q;
   assign hits     = cnt_q;

   assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(cur_q));
   assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      adv && (cur_q != last_q) |=> scanning && (cur_q == $past(cur_q) + ONE));
   assert_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
      adv && (cur_q == last_q) |=> fin_q && !scanning);
   assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fin_q |-> !scanning);
   assert_count_still_R7: assert property (@(posedge clk) disable iff (!rst_n)
      scanning && !(out_valid && out_ready) |=> cnt_q == $past(cnt_q));
   assert_empty_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      accept && empty |=> fin_q && !scanning && (cnt_q == '0));
endmodule

// File: rtl/ssk_range_kernel.sv
module ssk_range_kernel
   import ssk_pkg::*;
#(
   parameter int M          = 8,
   parameter int WW         = 8,
   parameter bit ADDER_TREE = 1'b1,
   localparam int IDX_W     = (M > 1) ? $clog2(M) : 1,
   localparam int SUM_W     = sk_sum_width(M, WW),
   localparam int CW        = M + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wt_we,
   input  logic [IDX_W-1:0] wt_idx,
   input  logic [WW-1:0]    wt_data,
   input  logic [SUM_W-1:0] target,
   input  logic [M-1:0]     start_mask,
   input  logic [M-1:0]     end_mask,
   input  logic             go,
   output logic             match_valid,
   input  logic             match_ready,
   output logic [M-1:0]     match_mask,
   output logic             busy,
   output logic             done,
   output logic [CW-1:0]    match_count
);
   if (M < 1 || M > 32) begin : g_bad_m
      $error("ssk_range_kernel: M must lie in 1..32");
   end
   if (WW < 1) begin : g_bad_ww
      $error("ssk_range_kernel: WW must be at least 1");
   end

   logic [M*WW-1:0]  w_flat;
   logic [M-1:0]     cur;
   logic [SUM_W-1:0] total, tgt_q;
   logic             hit, scanning;

   ssk_weight_bank #(.M(M), .WW(WW), .IDX_W(IDX_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wt_we && !scanning),
      .wr_idx (wt_idx),
      .wr_val (wt_data),
      .w_flat (w_flat)
   );

   ssk_sum_unit #(.M(M), .WW(WW), .SW(SUM_W), .ADDER_TREE(ADDER_TREE)) u_sum (
      .w_flat (w_flat),
      .sel    (cur),
      .total  (total)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         tgt_q <= '0;
      else if (go && !scanning)
         tgt_q <= target;
   end

   assign hit = (total == tgt_q);

   ssk_walker #(.M(M), .CW(CW)) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .first     (start_mask),
      .last      (end_mask),
      .hit       (hit),
      .out_ready (match_ready),
      .cur       (cur),
      .out_valid (match_valid),
      .scanning  (scanning),
      .finished  (done),
      .hits      (match_count)
   );

   assign match_mask = cur;
   assign busy       = scanning;

   assert_weights_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
      scanning |=> $stable(w_flat));
   assert_target_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
      scanning |=> $stable(tgt_q));
   assert_empty_mask_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == '0) |-> (total == '0));
endmodule

// File: tb/ssk_range_kernel_tb.sv
module ssk_range_kernel_tb;
   localparam int M  = 8;
   localparam int WW = 8;
   localparam int SW = 12;
   localparam int NV = 6;
   localparam int V_TGT [NV] = '{15, 20, 0, 54, 10, 100};
   localparam int V_LO  [NV] = '{0, 16, 0, 250, 5, 0};
   localparam int V_HI  [NV] = '{255, 200, 10, 255, 5, 255};
   localparam int V_RDY [NV] = '{0, 1, 2, 1, 0, 0};
   localparam int BASE_W [M] = '{3, 5, 7, 11, 13, 2, 9, 4};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wt_we = 1'b0;
   logic [2:0]    wt_idx = '0;
   logic [WW-1:0] wt_data = '0;
   logic [SW-1:0] target = '0;
   logic [M-1:0]  start_mask = '0, end_mask = '0;
   logic          go = 1'b0;
   logic          match_valid, match_ready = 1'b1;
   logic [M-1:0]  match_mask;
   logic          busy, done;
   logic [M:0]    match_count;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;
   int bw [M];

   always #5 clk = ~clk;

   ssk_range_kernel #(.M(M), .WW(WW)) u_dut (
      .clk(clk), .rst_n(rst_n), .wt_we(wt_we), .wt_idx(wt_idx), .wt_data(wt_data),
      .target(target), .start_mask(start_mask), .end_mask(end_mask), .go(go),
      .match_valid(match_valid), .match_ready(match_ready), .match_mask(match_mask),
      .busy(busy), .done(done), .match_count(match_count)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int ref_sum(input int m);
      int s = 0;
      for (int i = 0; i < M; i++) if (m[i]) s += bw[i];
      return s;
   endfunction

   task automatic put_weight(input int i, input int v);
      @(negedge clk);
      wt_we = 1'b1; wt_idx = 3'(i); wt_data = 8'(v);
      @(negedge clk);
      wt_we = 1'b0;
      bw[i] = v;
   endtask

   task automatic run(input int tg, input int lo, input int hi, input int rmode, input bit poke);
      int exp_m [256];
      int nexp = 0, got = 0, stalls = 0, busyc = 0, k = 0;
      for (int m = lo; m <= hi; m++) if (ref_sum(m) == tg) begin exp_m[nexp] = m; nexp++; end
      @(negedge clk);
      target = 12'(tg); start_mask = 8'(lo); end_mask = 8'(hi); go = 1'b1;
      @(posedge clk);
      while (k < 2000) begin
         @(negedge clk);
         go = 1'b0; wt_we = 1'b0;
         target = ~target; start_mask = 8'(hi); end_mask = 8'(lo);
         if (poke && k == 3) begin
            wt_we = 1'b1; wt_idx = 3'd0; wt_data = 8'd200; go = 1'b1;
         end
         match_ready = (rmode == 0) || (rmode == 1 && k[0]) || (rmode == 2 && (k % 3 == 0));
         if (!busy) break;
         busyc++;
         if (match_valid) begin
            if (match_ready) begin
               if (got < nexp)
                  check(int'(match_mask) == exp_m[got], "R5 match mask", int'(match_mask), exp_m[got]);
               else
                  check(1'b0, "R5 extra match", int'(match_mask), -1);
               got++;
            end else stalls++;
         end
         k++;
      end
      wt_we = 1'b0; match_ready = 1'b1;
      check(got == nexp, "R4 number of matches", got, nexp);
      check(busyc == hi - lo + 1 + stalls, "R4 cycles in search", busyc, hi - lo + 1 + stalls);
      check(done == 1'b1, "R6 done after last mask", int'(done), 1);
      check(int'(match_count) == nexp, "R7 match count", int'(match_count), nexp);
      check(match_valid == 1'b0, "R5 no valid when idle", int'(match_valid), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0 && done == 1'b0, "R9 reset busy/done", int'({busy, done}), 0);
      check(match_valid == 1'b0, "R9 reset valid", int'(match_valid), 0);
      check(match_count == '0, "R9 reset count", int'(match_count), 0);
      for (int i = 0; i < M; i++) bw[i] = 0;
      run(0, 0, 3, 0, 1'b0);            // R9: all weights zero, every mask matches target 0
      for (int i = 0; i < M; i++) put_weight(i, BASE_W[i]);   // R1 loads
      for (int v = 0; v < NV; v++) run(V_TGT[v], V_LO[v], V_HI[v], V_RDY[v], 1'b0);
      // R1/R2: weight write and go pulse in mid-run are ignored
      run(15, 0, 255, 1, 1'b1);
      run(15, 0, 255, 0, 1'b0);
      // R8: empty range after a run with matches
      @(negedge clk);
      start_mask = 8'd9; end_mask = 8'd3; target = 12'd15; go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      check(busy == 1'b0, "R8 empty range busy", int'(busy), 0);
      check(done == 1'b1, "R8 empty range done", int'(done), 1);
      check(match_count == '0, "R8 empty range count", int'(match_count), 0);
      // R3: maximal weights, no overflow
      for (int i = 0; i < M; i++) put_weight(i, 255);
      run(2040, 0, 255, 0, 1'b0);
      run(1785, 0, 255, 2, 1'b0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      finished = 1'b1;
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule